// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block keeps the configuration state of a vector execution unit. That state is the stored type word, the element width, the register grouping multiplier, the maximum vector length, the current vector length, the register-group mask, the mask element width and the start index. It updates the state whenever a set-vector-length operation executes. The decoder presents a new type word, a requested length and a two-bit source mode, and raises a one-cycle valid strobe. The unit returns the length it grants in that same cycle. On the clock edge the granted length becomes the new current length.

The type word is decoded as follows. Bits [4:2] select the element width. Bits [1:0] select the grouping multiplier. Bits [6:5] select a divide factor. Bits from 7 upward must be zero. A type that cannot be supported is flagged illegal, which leaves the unit with no usable vector length. The type-derived fields are recomputed only when the incoming type differs from the stored one. Decode, register-file access and trap handling belong to the surrounding pipeline.

Top module: `vcfg_unit`

## Requirements
- R1: When a differing type t is written, sew_o becomes 1 << (t[4:2] + 3) and lmul_o becomes 1 << t[1:0]. mask_ew_o becomes sew_o / lmul_o, and grp_mask_o becomes (NVREG-1) with its low (lmul_o-1) bits cleared.
- R2: A written type is illegal when its element width exceeds ELEN, when t[6:5] is nonzero, or when any bit t[XLEN-1:7] is set. In that case illegal_o is 1, vtype_o holds only bit XLEN-1 set, and vlmax_o is 0. Otherwise illegal_o is 0 and vtype_o equals t.
- R3: For a legal type, vlmax_o equals (VLEN / sew_o) * lmul_o.
- R4: With src_mode_i of 2'b00 or 2'b11 (ordinary source register), the granted length is req_len_i when that value does not exceed the maximum length, and the maximum length otherwise.
- R5: With src_mode_i = 2'b01 (source x0, destination not x0), the granted length is the current vl_o clamped to the maximum length.
- R6: With src_mode_i = 2'b10 (source and destination both x0), the granted length equals the maximum length.
- R7: If the maximum length in effect is 0, the granted length is 0 whatever the mode.
- R8: granted_len_o is valid combinationally in the cycle cfg_valid_i is high, and vl_o takes that value on the following clock edge.
- R9: Every execution leaves vstart_o at 0.
- R10: Writing a type equal to the stored vtype_o leaves every type-derived output unchanged. While cfg_valid_i is low, no output changes.
- R11: After reset, the state is that of an all-ones type written: illegal_o is 1, vtype_o holds only bit XLEN-1, and vlmax_o, vl_o and vstart_o are 0. sew_o is 1024, lmul_o is 8, mask_ew_o is 128, and grp_mask_o is (NVREG-1) with the low 3 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid_i | input | 1 | Executes a configuration update this cycle |
| req_len_i | input | XLEN | Requested vector length |
| new_type_i | input | XLEN | Proposed type word |
| src_mode_i | input | 2 | 00/11 ordinary source, 01 keep length, 10 maximise length |
| granted_len_o | output | VL_W | Length granted by the current request |
| vtype_o | output | XLEN | Stored type word |
| illegal_o | output | 1 | Stored configuration is illegal |
| sew_o | output | 11 | Element width in bits |
| lmul_o | output | 4 | Register grouping multiplier |
| vlmax_o | output | VL_W | Maximum vector length |
| vl_o | output | VL_W | Current vector length |
| grp_mask_o | output | log2(NVREG) | Register-group alignment mask |
| mask_ew_o | output | 11 | Mask element width |
| vstart_o | output | VL_W | Start index |

## Verification
The bench writes a type whose element width sits exactly at ELEN. A design that compared with the wrong inequality would flag it illegal and report a zero maximum. The bench requests a length equal to the maximum and one of all ones; an off-by-one clamp or a truncated comparison would grant the wrong value. The keep mode runs after the type has shrunk the maximum, so a design that failed to clamp would carry over an oversized length. After an illegal write, the bench writes the sign-only type that is already stored. A design that recomputed anyway, or ignored the zero-maximum rule in maximise mode, would leave a nonzero length.

// File: rtl/vcfg_pkg.sv
// Package: shared encodings and fixed field widths of the vector
// configuration unit. Assumes the type-word layout used by vcfg_decode.
package vcfg_pkg;

    // Field positions inside the type word
    localparam int LMUL_LSB  = 0;
    localparam int SEW_LSB   = 2;
    localparam int DIV_LSB   = 5;
    localparam int RSVD_LSB  = 7;

    // A 3-bit width selector reaches 1 << 10, which needs 11 bits
    localparam int SEW_W     = 11;
    // A 2-bit multiplier selector reaches 8, which needs 4 bits
    localparam int LMUL_W    = 4;

    // Source-register mode codes
    typedef enum logic [1:0] {
        MODE_CLAMP     = 2'b00,
        MODE_KEEP      = 2'b01,
        MODE_MAX       = 2'b10,
        MODE_CLAMP_ALT = 2'b11
    } src_mode_e;

endpackage

// File: rtl/vcfg_decode.sv
// Module: vcfg_decode
// Purely combinational decode of a type word into element width,
// multiplier, mask element width, register-group mask, maximum length
// and the illegal flag. Assumes VLEN and ELEN are powers of two and
// that NVREG is at least 8.
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int NVREG = 32,
    parameter int VL_W  = $clog2(VLEN + 1),
    parameter int GM_W  = $clog2(NVREG)
) (
    input  logic [XLEN-1:0]   type_i,
    output logic [SEW_W-1:0]  sew_o,
    output logic [LMUL_W-1:0] lmul_o,
    output logic [SEW_W-1:0]  mask_ew_o,
    output logic [GM_W-1:0]   grp_mask_o,
    output logic [VL_W-1:0]   vlmax_o,
    output logic              illegal_o
);

    logic [2:0]  sew_sel;
    logic [1:0]  lmul_sel;
    logic [1:0]  div_sel;
    logic [3:0]  sew_shamt;
    logic        rsvd_set;
    logic [31:0] per_reg;
    logic [31:0] grouped;

    // Split the type word into its selector fields
    always_comb begin
        sew_sel  = type_i[SEW_LSB +: 3];
        lmul_sel = type_i[LMUL_LSB +: 2];
        div_sel  = type_i[DIV_LSB +: 2];
        rsvd_set = |type_i[XLEN-1:RSVD_LSB];
        sew_shamt = {1'b0, sew_sel} + 4'd3;
    end

    // Derive widths, multiplier and register-group mask
    always_comb begin
        sew_o      = SEW_W'(1) << sew_shamt;
        lmul_o     = LMUL_W'(1) << lmul_sel;
        mask_ew_o  = sew_o >> lmul_sel;
        grp_mask_o = GM_W'(NVREG - 1) & ~GM_W'(lmul_o - LMUL_W'(1));
    end

    // Legality and maximum length
    always_comb begin
        illegal_o = (32'(sew_o) > 32'(ELEN)) || (div_sel != 2'd0) || rsvd_set;
        per_reg   = 32'(VLEN) >> sew_shamt;
        grouped   = per_reg << lmul_sel;
        vlmax_o   = illegal_o ? '0 : VL_W'(grouped);
    end

endmodule

// File: rtl/vcfg_len_sel.sv
// Module: vcfg_len_sel
// Combinational choice of the granted vector length from the source
// mode, the requested length, the current length and the maximum
// length in effect. Assumes cur_vl_i never exceeds VLEN.
module vcfg_len_sel
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VL_W = 8
) (
    input  logic [1:0]      mode_i,
    input  logic [XLEN-1:0] req_i,
    input  logic [VL_W-1:0] cur_vl_i,
    input  logic [VL_W-1:0] vlmax_i,
    output logic [VL_W-1:0] granted_o
);

    src_mode_e mode;
    logic      req_over;
    logic      cur_over;

    // Compare the candidate lengths against the maximum
    always_comb begin
        mode     = src_mode_e'(mode_i);
        req_over = req_i > XLEN'(vlmax_i);
        cur_over = cur_vl_i > vlmax_i;
    end

    // Select the granted length by mode
    always_comb begin
        if (vlmax_i == '0) begin
            granted_o = '0;
        end else begin
            unique case (mode)
                MODE_KEEP: granted_o = cur_over ? vlmax_i : cur_vl_i;
                MODE_MAX:  granted_o = vlmax_i;
                default:   granted_o = req_over ? vlmax_i : VL_W'(req_i);
            endcase
        end
    end

endmodule

// File: rtl/vcfg_unit.sv
// Module: vcfg_unit
// Holds the vector configuration state and updates it on each strobe
// of cfg_valid_i. Type-derived state is rewritten only when the new
// type differs from the stored one. Synchronous active-low reset loads
// the state an all-ones type would produce.
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int NVREG = 32,
    parameter int VL_W  = $clog2(VLEN + 1),
    parameter int GM_W  = $clog2(NVREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid_i,
    input  logic [XLEN-1:0]   req_len_i,
    input  logic [XLEN-1:0]   new_type_i,
    input  logic [1:0]        src_mode_i,
    output logic [VL_W-1:0]   granted_len_o,
    output logic [XLEN-1:0]   vtype_o,
    output logic              illegal_o,
    output logic [SEW_W-1:0]  sew_o,
    output logic [LMUL_W-1:0] lmul_o,
    output logic [VL_W-1:0]   vlmax_o,
    output logic [VL_W-1:0]   vl_o,
    output logic [GM_W-1:0]   grp_mask_o,
    output logic [SEW_W-1:0]  mask_ew_o,
    output logic [VL_W-1:0]   vstart_o
);

    localparam logic [XLEN-1:0]   SIGN_ONLY   = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [SEW_W-1:0]  RST_SEW     = SEW_W'(1) << 10;
    localparam logic [LMUL_W-1:0] RST_LMUL    = LMUL_W'(8);
    localparam logic [SEW_W-1:0]  RST_MASK_EW = RST_SEW >> 3;
    localparam logic [GM_W-1:0]   RST_GRP     = GM_W'(NVREG - 1) & ~GM_W'(7);

    logic [SEW_W-1:0]  dec_sew;
    logic [LMUL_W-1:0] dec_lmul;
    logic [SEW_W-1:0]  dec_mask_ew;
    logic [GM_W-1:0]   dec_grp;
    logic [VL_W-1:0]   dec_vlmax;
    logic              dec_ill;
    logic              type_chg;
    logic [VL_W-1:0]   vlmax_eff;

    vcfg_decode #(
        .XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .NVREG(NVREG),
        .VL_W(VL_W), .GM_W(GM_W)
    ) u_decode (
        .type_i     (new_type_i),
        .sew_o      (dec_sew),
        .lmul_o     (dec_lmul),
        .mask_ew_o  (dec_mask_ew),
        .grp_mask_o (dec_grp),
        .vlmax_o    (dec_vlmax),
        .illegal_o  (dec_ill)
    );

    // Pick the maximum length that applies to this request
    always_comb begin
        type_chg  = new_type_i != vtype_o;
        vlmax_eff = type_chg ? dec_vlmax : vlmax_o;
    end

    vcfg_len_sel #(
        .XLEN(XLEN), .VL_W(VL_W)
    ) u_len_sel (
        .mode_i    (src_mode_i),
        .req_i     (req_len_i),
        .cur_vl_i  (vl_o),
        .vlmax_i   (vlmax_eff),
        .granted_o (granted_len_o)
    );

    // Type-derived state: reset to the all-ones image, rewrite on change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtype_o    <= SIGN_ONLY;
            illegal_o  <= 1'b1;
            sew_o      <= RST_SEW;
            lmul_o     <= RST_LMUL;
            mask_ew_o  <= RST_MASK_EW;
            grp_mask_o <= RST_GRP;
            vlmax_o    <= '0;
        end else if (cfg_valid_i && type_chg) begin
            vtype_o    <= dec_ill ? SIGN_ONLY : new_type_i;
            illegal_o  <= dec_ill;
            sew_o      <= dec_sew;
            lmul_o     <= dec_lmul;
            mask_ew_o  <= dec_mask_ew;
            grp_mask_o <= dec_grp;
            vlmax_o    <= dec_vlmax;
        end
    end

    // Length state: take the granted length and clear the start index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_o     <= '0;
            vstart_o <= '0;
        end else if (cfg_valid_i) begin
            vl_o     <= granted_len_o;
            vstart_o <= '0;
        end
    end

endmodule

// File: rtl/vcfg_unit_chk.sv
// Module: vcfg_unit_chk
// Property checker for vcfg_unit, attached through bind below.
// Assumes the synchronous active-low reset of the unit.
module vcfg_unit_chk #(
    parameter int XLEN = 64,
    parameter int ELEN = 64,
    parameter int VL_W = 8,
    parameter int SW   = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_valid_i,
    input logic [1:0]      src_mode_i,
    input logic [VL_W-1:0] granted_len_o,
    input logic [XLEN-1:0] vtype_o,
    input logic            illegal_o,
    input logic [SW-1:0]   sew_o,
    input logic [VL_W-1:0] vlmax_o,
    input logic [VL_W-1:0] vl_o,
    input logic [VL_W-1:0] vstart_o
);

    localparam logic [XLEN-1:0] SIGN_ONLY = {1'b1, {(XLEN-1){1'b0}}};

    // R2: illegal state carries sign-only type and no length
    a_r2_illegal_state: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (vtype_o == SIGN_ONLY && vlmax_o == '0 && vl_o == '0));

    // R1: a legal configuration never exceeds ELEN
    a_r1_legal_width: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_o |-> (32'(sew_o) <= 32'(ELEN)));

    // R4: current length never above maximum
    a_r4_vl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        vl_o <= vlmax_o);

    // R6: maximise mode lands on the maximum length
    a_r6_max_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && src_mode_i == 2'b10) |=> (vl_o == vlmax_o));

    // R8: granted length becomes the current length
    a_r8_granted_taken: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_i |=> (vl_o == $past(granted_len_o)));

    // R9: start index cleared by every execution
    a_r9_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_i |=> (vstart_o == '0));

    // R10: no change without a strobe
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid_i |=> ($stable(vl_o) && $stable(vtype_o) && $stable(vlmax_o)));

endmodule

bind vcfg_unit vcfg_unit_chk #(
    .XLEN(XLEN), .ELEN(ELEN), .VL_W(VL_W), .SW(vcfg_pkg::SEW_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_valid_i   (cfg_valid_i),
    .src_mode_i    (src_mode_i),
    .granted_len_o (granted_len_o),
    .vtype_o       (vtype_o),
    .illegal_o     (illegal_o),
    .sew_o         (sew_o),
    .vlmax_o       (vlmax_o),
    .vl_o          (vl_o),
    .vstart_o      (vstart_o)
);

// File: tb/test_vcfg_unit.sv
// Bench: scoreboard for vcfg_unit. The driver task models the expected
// state from the requirements and queues it. The monitor pops and
// compares it one falling edge after the update.
module test_vcfg_unit;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 64;
    localparam int VLEN  = 128;
    localparam int ELEN  = 64;
    localparam int NVREG = 32;
    localparam int VL_W  = $clog2(VLEN + 1);
    localparam int GM_W  = $clog2(NVREG);
    localparam logic [63:0] SIGN_ONLY = 64'h8000_0000_0000_0000;

    typedef struct {
        logic [63:0] ty;
        bit          ill;
        int          sew;
        int          lmul;
        int          vlmax;
        int          vl;
        int          gm;
        int          mew;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_valid_i = 1'b0;
    logic [XLEN-1:0]   req_len_i = '0;
    logic [XLEN-1:0]   new_type_i = '0;
    logic [1:0]        src_mode_i = 2'b00;
    logic [VL_W-1:0]   granted_len_o;
    logic [XLEN-1:0]   vtype_o;
    logic              illegal_o;
    logic [10:0]       sew_o;
    logic [3:0]        lmul_o;
    logic [VL_W-1:0]   vlmax_o;
    logic [VL_W-1:0]   vl_o;
    logic [GM_W-1:0]   grp_mask_o;
    logic [10:0]       mask_ew_o;
    logic [VL_W-1:0]   vstart_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];
    exp_t m;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcfg_unit #(
        .XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .NVREG(NVREG)
    ) i_vcfg_unit (
        .clk(clk), .rst_n(rst_n), .cfg_valid_i(cfg_valid_i),
        .req_len_i(req_len_i), .new_type_i(new_type_i), .src_mode_i(src_mode_i),
        .granted_len_o(granted_len_o), .vtype_o(vtype_o), .illegal_o(illegal_o),
        .sew_o(sew_o), .lmul_o(lmul_o), .vlmax_o(vlmax_o), .vl_o(vl_o),
        .grp_mask_o(grp_mask_o), .mask_ew_o(mask_ew_o), .vstart_o(vstart_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare every stored output with one expected image
    task automatic chk_state(input exp_t e);
        chk(e.tag, "vtype",    vtype_o, e.ty);
        chk(e.tag, "illegal",  64'(illegal_o), 64'(e.ill));
        chk(e.tag, "sew",      64'(sew_o), 64'(e.sew));
        chk(e.tag, "lmul",     64'(lmul_o), 64'(e.lmul));
        chk(e.tag, "vlmax",    64'(vlmax_o), 64'(e.vlmax));
        chk(e.tag, "vl",       64'(vl_o), 64'(e.vl));
        chk(e.tag, "grp_mask", 64'(grp_mask_o), 64'(e.gm));
        chk(e.tag, "mask_ew",  64'(mask_ew_o), 64'(e.mew));
        chk(e.tag, "vstart R9", 64'(vstart_o), 64'd0);
    endtask

    // Expected decode of a type word (R1, R2, R3)
    task automatic model_decode(input logic [63:0] t);
        int s;
        int l;
        s = 1 << (int'(t[4:2]) + 3);
        l = 1 << int'(t[1:0]);
        m.sew  = s;
        m.lmul = l;
        m.mew  = s / l;
        m.gm   = (NVREG - 1) & ~(l - 1);
        m.ill  = (s > ELEN) || (t[6:5] != 2'b00) || ((t >> 7) != 64'd0);
        m.vlmax = m.ill ? 0 : (VLEN / s) * l;
        m.ty   = m.ill ? SIGN_ONLY : t;
    endtask

    // Driver: one execution, granted length checked before the edge
    task automatic exec(input logic [63:0] t, input logic [63:0] req,
                        input logic [1:0] mode, input string tag);
        int g;
        @(negedge clk);
        cfg_valid_i = 1'b1;
        new_type_i  = t;
        req_len_i   = req;
        src_mode_i  = mode;
        if (t != m.ty) model_decode(t);
        if (m.vlmax == 0)       g = 0;
        else if (mode == 2'b01) g = (m.vl > m.vlmax) ? m.vlmax : m.vl;
        else if (mode == 2'b10) g = m.vlmax;
        else                    g = (req > 64'(m.vlmax)) ? m.vlmax : int'(req);
        m.vl  = g;
        m.tag = tag;
        #1;
        chk({tag, " R8"}, "granted", 64'(granted_len_o), 64'(g));
        sb_q.push_back(m);
        @(posedge clk);
        #1 cfg_valid_i = 1'b0;
    endtask

    // Monitor: pop and compare after each update has settled
    always @(negedge clk) begin
        if (sb_q.size() > 0) chk_state(sb_q.pop_front());
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11 reset image: all-ones type decoded
        m.ty = SIGN_ONLY; m.ill = 1'b1; m.sew = 1024; m.lmul = 8;
        m.mew = 128; m.gm = (NVREG - 1) & ~7; m.vlmax = 0; m.vl = 0;
        m.tag = "R11";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk_state(m);

        exec(64'h0,  64'd10, 2'b00, "R4 clamp below");          // vlmax 16
        exec(64'h0,  64'd20, 2'b00, "R4 clamp above");          // -> 16
        exec(64'h8,  64'd99, 2'b01, "R5 keep shrinks");         // e32 m1 vlmax 4
        exec(64'h7,  64'd0,  2'b10, "R6 maximise");             // e16 m8 vlmax 64
        exec(64'h7,  64'd0,  2'b01, "R5 R10 keep same type");   // stays 64
        exec(64'hC,  64'd1,  2'b11, "R1 R3 width at ELEN");     // e64 vlmax 2
        exec(64'h2,  64'd64, 2'b00, "R4 req equal max");        // e8 m4 vlmax 64
        exec(64'h2,  {64{1'b1}}, 2'b11, "R4 req all ones");
        exec(64'h10, 64'd5,  2'b00, "R2 width over ELEN");
        exec(SIGN_ONLY, 64'd5, 2'b10, "R7 R10 sign-only unchanged");
        exec(64'h20, 64'd5,  2'b01, "R2 divide factor");
        exec(64'h5,  64'd3,  2'b00, "R1 e16 m2 recover");
        exec(64'h80, 64'd3,  2'b10, "R2 R7 reserved bit");
        exec(64'h1,  64'd7,  2'b00, "R1 e8 m2");

        // R10: no strobe, inputs wiggle, state must hold
        @(negedge clk);
        new_type_i = 64'h3; req_len_i = 64'd1; src_mode_i = 2'b10;
        repeat (3) @(negedge clk);
        m.tag = "R10 idle";
        chk_state(m);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule